// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is a row of N boundary-scan cells placed between a core's signals and the device pins. Each cell takes a parallel value from the pin or core side, passes a value on to the other side, and joins a serial path that runs from a chain input through every cell to a chain output. Each cell holds two pieces of state. A capture/shift flop loads either the parallel input or the serial bit from the cell before it. An update latch copies the capture/shift flop and holds the value that is driven out in test mode.

The capture/shift stage acts on the rising edge of the test clock, and only while the capture enable is high. The update latch loads on the falling edge, and only while the update enable is high. Test-mode select picks the value that reaches the parallel output. With it low, each cell is transparent and the output follows the parallel input. With it high, each output shows the held update value. A test cycle shifts a vector in, updates it onto the outputs, captures the responses and shifts them out while the next vector shifts in. With test mode low the chain can still capture, shift and update. This preloads a first vector before external test begins.

Top module: `bscan_chain`

## Requirements
- R1: With test_mode low and reset released, par_out equals pin_in on every bit.
- R2: With test_mode high and reset released, par_out bit i equals the update latch of cell i.
- R3: On a rising tck edge with capture_en high and shift_sel low, every capture/shift flop loads its pin_in bit, so scan_out then shows pin_in[N-1].
- R4: On a rising tck edge with capture_en and shift_sel both high, cell 0 loads scan_in, cell i loads cell i-1 and scan_out shows cell N-1. A vector that enters most-significant bit first therefore sits in cell order after N shifts.
- R5: On a rising tck edge with capture_en low, no capture/shift flop changes.
- R6: On a falling tck edge with update_en high, each update latch loads its cell's capture/shift flop.
- R7: On a falling tck edge with update_en low, the update latches hold, so par_out in test mode does not change while data shifts.
- R8: While rst_n is low, all flops and latches are cleared to 0 and par_out equals pin_in whatever test_mode is; after release in test mode par_out reads 0 and scan_out reads 0.
- R9: With test_mode low, capture, shift and update still operate without disturbing par_out, and a later rise of test_mode drives the preloaded vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; capture/shift on rising edge, update on falling edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_in | input | 1 | Serial input to cell 0 |
| shift_sel | input | 1 | 1 selects serial shift, 0 selects parallel capture |
| capture_en | input | 1 | Clock enable for the capture/shift stage |
| update_en | input | 1 | Enable for the update latches |
| test_mode | input | 1 | 1 drives update latches onto par_out, 0 is transparent |
| pin_in | input | N | Parallel inputs, one per cell |
| par_out | output | N | Parallel outputs, one per cell |
| scan_out | output | 1 | Serial output of cell N-1 |

## Verification
A wrong capture/shift bit reaches scan_out within at most N rising edges of shifting. It is also driven onto par_out after the next falling-edge update in test mode. A wrong update latch shows on par_out as soon as test_mode is high, and stays there until the next update. This makes stuck or stale latches visible within one cycle of entering test mode. The bench keeps its own model of both state rows and compares par_out and scan_out after every falling edge, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N = 8
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         scan_in,
  input  logic         shift_sel,
  input  logic         capture_en,
  input  logic         update_en,
  input  logic         test_mode,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] par_out,
  output logic         scan_out
);

  logic [N-1:0] cap_q;
  logic [N-1:0] upd_q;
  logic [N-1:0] ser_in;

  for (genvar i = 0; i < N; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign ser_in[i] = scan_in;
    end else begin : g_link
      assign ser_in[i] = cap_q[i-1];
    end

    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)          cap_q[i] <= 1'b0;
      else if (capture_en) cap_q[i] <= shift_sel ? ser_in[i] : pin_in[i];
    end

    always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)         upd_q[i] <= 1'b0;
      else if (update_en) upd_q[i] <= cap_q[i];
    end

    assign par_out[i] = (test_mode && rst_n) ? upd_q[i] : pin_in[i];
  end

  assign scan_out = cap_q[N-1];

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N = 8
) (
  input logic         tck,
  input logic         rst_n,
  input logic         scan_in,
  input logic         shift_sel,
  input logic         capture_en,
  input logic         update_en,
  input logic         test_mode,
  input logic [N-1:0] pin_in,
  input logic [N-1:0] par_out,
  input logic         scan_out,
  input logic [N-1:0] cap_q,
  input logic [N-1:0] upd_q
);

  always_comb begin
    if (rst_n === 1'b0)
      AST_RESET_TRANSPARENT: assert (par_out === pin_in); // R8
  end

  AST_TRANSPARENT: assert property (@(posedge tck) disable iff (!rst_n)
    !test_mode |-> par_out == pin_in); // R1
  AST_TEST_DRIVE: assert property (@(posedge tck) disable iff (!rst_n)
    test_mode |-> par_out == upd_q); // R2
  AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!rst_n)
    capture_en && !shift_sel |=> cap_q == $past(pin_in) && scan_out == $past(pin_in[N-1])); // R3
  AST_SHIFT_STEP: assert property (@(posedge tck) disable iff (!rst_n)
    capture_en && shift_sel |=> cap_q == {$past(cap_q[N-2:0]), $past(scan_in)}); // R4
  AST_CAPTURE_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    !capture_en |=> $stable(cap_q)); // R5
  AST_UPDATE_LOAD: assert property (@(negedge tck) disable iff (!rst_n)
    update_en |=> upd_q == $past(cap_q)); // R6
  AST_UPDATE_HOLD: assert property (@(negedge tck) disable iff (!rst_n)
    !update_en |=> $stable(upd_q)); // R7

endmodule

bind bscan_chain bscan_chain_chk #(.N(N)) u_chk (.*);

// File: tb/tb_bscan_chain.sv
`timescale 1ns/1ps
module tb_bscan_chain;
  localparam int N = 8;

  logic tck = 1'b0;
  logic rst_n, scan_in, shift_sel, capture_en, update_en, test_mode;
  logic [N-1:0] pin_in, par_out;
  logic scan_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] m_cap, m_upd;

  always #2.5 tck = ~tck;

  bscan_chain #(.N(N)) dut (.*);

  function automatic logic [N-1:0] exp_par(logic rn, logic tm, logic [N-1:0] upd, logic [N-1:0] pin);
    return (rn && tm) ? upd : pin;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_in(logic si, logic sh, logic ce, logic ue, logic tm, logic [N-1:0] pin);
    scan_in = si; shift_sel = sh; capture_en = ce; update_en = ue; test_mode = tm; pin_in = pin;
  endtask

  task automatic cyc(string tag);
    @(posedge tck);
    if (!rst_n) m_cap = '0;
    else if (capture_en) m_cap = shift_sel ? {m_cap[N-2:0], scan_in} : pin_in;
    @(negedge tck);
    if (!rst_n) m_upd = '0;
    else if (update_en) m_upd = m_cap;
    #1;
    chk(tag, par_out, exp_par(rst_n, test_mode, m_upd, pin_in));
    chk(tag, {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, m_cap[N-1]});
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] vec, pins, held;
    void'($urandom(32'h5eed_1149));
    m_cap = '0; m_upd = '0;
    rst_n = 1'b0;
    set_in(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA5);
    #1;
    chk("R8", par_out, 8'hA5);
    cyc("R8");
    pin_in = 8'h3C; #1;
    chk("R8", par_out, 8'h3C);
    @(negedge tck); #1;
    rst_n = 1'b1;
    set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF);
    #0.5;
    chk("R8", par_out, 8'h00);
    chk("R8", {7'd0, scan_out}, 8'h00);

    // R9: preload with test_mode low
    vec = 8'h96;
    for (int k = N - 1; k >= 0; k--) begin
      set_in(vec[k], 1'b1, 1'b1, 1'b0, 1'b0, N'($urandom));
      cyc("R1");
    end
    set_in(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A);
    cyc("R9");
    chk("R9", par_out, 8'h5A);
    set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    #1;
    chk("R9", par_out, vec);

    // R7: shift new data in test mode with update off
    for (int k = 0; k < N; k++) begin
      set_in(1'($urandom), 1'b1, 1'b1, 1'b0, 1'b1, N'($urandom));
      cyc("R7");
      chk("R7", par_out, vec);
    end
    set_in(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    cyc("R6");
    held = m_upd;
    chk("R6", par_out, held);

    // R3 then R4: capture pins, shift them out
    pins = 8'hC3;
    set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, pins);
    cyc("R3");
    for (int k = N - 1; k >= 1; k--) begin
      chk("R4", {7'd0, scan_out}, {7'd0, pins[k]});
      set_in(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
      cyc("R4");
    end
    chk("R4", {7'd0, scan_out}, {7'd0, pins[0]});

    // R5: capture disabled
    held = {7'd0, scan_out};
    for (int k = 0; k < 6; k++) begin
      set_in(1'($urandom), 1'($urandom), 1'b0, 1'b0, 1'b1, N'($urandom));
      cyc("R5");
      chk("R5", {7'd0, scan_out}, held);
    end

    // R1/R2 random mix
    for (int k = 0; k < 400; k++) begin
      set_in(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), N'($urandom));
      cyc(test_mode ? "R2" : "R1");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule